// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the configuration port of a larger chip. An external host reaches a byte-wide register space over a three-wire serial link made of a shift clock, an active-low select and a single data line. The data line turns around inside a frame so that the host can read registers back. The pad-side line is split into an input, an output and an output enable. All serial inputs pass through a synchronizer into the chip clock domain, so the serial clock must run well below the chip clock.

Every frame begins with a 16-bit instruction. The top bit selects read (1) or write (0). The next two bits select a length code. The low 13 bits give the starting address. One or more data bytes follow. The address steps after each byte. The bit order of the whole frame can be switched between most-significant-first and least-significant-first. A transfer may run as an endless stream, and it may pause with the select high between bytes. A self-clearing soft reset returns most registers to their defaults.

A channel index register steers writes to a window of per-channel registers, so that one or both copies receive the same byte. The remaining registers are plain storage.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset `sdio_oe` is 0. Register 0x00 reads 0x18, and the channel index at 0x05 reads 0.
- R2: The instruction is 16 bits, sampled on rising serial clock edges while the select is low. Bit 15 is read(1)/write(0), bits 14:13 are the length code and bits 12:0 are the address. In most-significant-first order bit 15 is sent first.
- R3: Length codes 0, 1 and 2 move exactly 1, 2 and 3 bytes. Further bytes in the same frame write nothing.
- R4: Length code 3 streams bytes until the select rises. In most-significant-first order the address increments by one after each byte.
- R5: In a read, `sdio_oe` is 1 during each data bit while the select is low, and `sdio_out` changes only after serial clock falling edges. The first bit appears after the falling edge that follows the last instruction bit. `sdio_oe` is 0 throughout writes and while the select is high.
- R6: Writing 0x00 with bit 6 or bit 1 set selects least-significant-first order for the instruction and the data bytes, from the next frame on. In that order the address decrements after each byte. The mode reads back in both bits 6 and 1.
- R7: Writing 0x00 with bit 5 or bit 2 set returns every register except 0x00, 0x09 and 0x0A to its default (0). The reset bit reads back as 0 afterwards.
- R8: Address 0x01 is read-only and returns 0x22. Writes to it have no effect.
- R9: The channel index at 0x05 steers writes to 0x10–0x17: value 1 writes channel A only, 2 channel B only, and 0 or 3 both. Reads return the channel B copy when the index is 2 and the channel A copy otherwise.
- R10: A select high at a byte boundary of an unfinished fixed-length frame pauses it, and the next select-low period continues with the next byte. A select rising in the middle of a byte ends the frame, and the partial byte is not written.
- R11: Addresses 0x08, 0x09 and 0x0A are read/write storage. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial shift clock, idle low |
| csb | input | 1 | Active-low frame select |
| sdio_in | input | 1 | Data line as seen from the pad |
| sdio_out | output | 1 | Read data to drive onto the line |
| sdio_oe | output | 1 | Drive enable for the data line |

## Verification
The bench targets the byte boundaries. A fixed-length write sends one byte too many, and a wrong length decode would corrupt the next register. A frame that pauses at a byte boundary would write the wrong address, or lose the byte, if the pause were treated as the end of the frame. A frame cut mid-byte would write a garbage byte if the partial data were committed. Least-significant-first frames check that the address counts downward and that the new mode only applies from the next frame. A soft reset check covers a design that clears the spared registers or leaves its reset bit stuck. Read frames sample the data line both before and after each rising edge, which exposes output that changes on the wrong edge or drives during writes.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int INSTR_W = 16;
  localparam int ADDR_W  = 13;
  localparam int BYTE_W  = 8;
  localparam int LEN_W   = 2;
  localparam int CNT_W   = $clog2(INSTR_W);

  localparam logic [ADDR_W-1:0] A_CFG  = 13'h000;
  localparam logic [ADDR_W-1:0] A_ID   = 13'h001;
  localparam logic [ADDR_W-1:0] A_CHAN = 13'h005;

  localparam logic [LEN_W-1:0] LEN_STREAM = 2'd3;

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_t;

  function automatic logic [INSTR_W-1:0] shift_word(logic [INSTR_W-1:0] cur, logic b, logic lsb);
    return lsb ? {b, cur[INSTR_W-1:1]} : {cur[INSTR_W-2:0], b};
  endfunction

  function automatic logic [BYTE_W-1:0] shift_byte(logic [BYTE_W-1:0] cur, logic b, logic lsb);
    return lsb ? {b, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], b};
  endfunction

  function automatic logic [ADDR_W-1:0] next_addr(logic [ADDR_W-1:0] a, logic lsb);
    return lsb ? a - 1'b1 : a + 1'b1;
  endfunction

  function automatic logic [2:0] bit_pick(logic [2:0] cnt, logic lsb);
    return lsb ? cnt : 3'd7 - cnt;
  endfunction

  function automatic logic [BYTE_W-1:0] cfg_view(logic lsb, logic srst);
    return {1'b0, lsb, srst, 1'b1, 1'b1, srst, lsb, 1'b0};
  endfunction

  function automatic logic chan_hit(logic [1:0] idx, int c);
    return (idx == 2'd0) || (idx == 2'd3) || (int'(idx) == c + 1);
  endfunction
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic csb,
  input  logic sdio_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic csb_low,
  output logic csb_rise,
  output logic sdio_s
);
  localparam logic [2:0] IDLE_V = 3'b010;

  logic [2:0] stg [STAGES];
  logic       sclk_q, csb_q;
  logic       sclk_s, csb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE_V;
      sclk_q <= 1'b0;
      csb_q  <= 1'b1;
    end else begin
      stg[0] <= {sclk, csb, sdio_in};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sclk_q <= sclk_s;
      csb_q  <= csb_s;
    end
  end

  assign sclk_s    = stg[STAGES-1][2];
  assign csb_s     = stg[STAGES-1][1];
  assign sdio_s    = stg[STAGES-1][0];
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign csb_low   = ~csb_s;
  assign csb_rise  = csb_s & ~csb_q;
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              csb_low,
  input  logic              csb_rise,
  input  logic              sdio_s,
  input  logic              cfg_lsb,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdio_out,
  output logic              sdio_oe
);
  phase_t             phase;
  logic [CNT_W-1:0]   bitcnt;
  logic [INSTR_W-1:0] ish;
  logic [BYTE_W-1:0]  dsh;
  logic               is_rd;
  logic [LEN_W-1:0]   len;
  logic [LEN_W-1:0]   nbytes;
  logic               lsb_f;

  logic               lsb_cur;
  logic [INSTR_W-1:0] ish_nx;
  logic [BYTE_W-1:0]  dsh_nx;
  logic               take, instr_end, byte_end, last_byte, stall_ok;

  assign lsb_cur   = (phase == PH_INSTR && bitcnt == '0) ? cfg_lsb : lsb_f;
  assign ish_nx    = shift_word(ish, sdio_s, lsb_cur);
  assign dsh_nx    = shift_byte(dsh, sdio_s, lsb_f);
  assign take      = sclk_rise & csb_low;
  assign instr_end = take && phase == PH_INSTR && bitcnt == CNT_W'(INSTR_W - 1);
  assign byte_end  = take && phase == PH_DATA && bitcnt == CNT_W'(BYTE_W - 1);
  assign last_byte = (len != LEN_STREAM) && (nbytes == len);
  assign stall_ok  = (phase == PH_DATA) && (bitcnt == '0) && (len != LEN_STREAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_INSTR;
      bitcnt   <= '0;
      ish      <= '0;
      dsh      <= '0;
      is_rd    <= 1'b0;
      len      <= '0;
      nbytes   <= '0;
      lsb_f    <= 1'b0;
      addr     <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sdio_out <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (csb_rise && !stall_ok) begin
        phase  <= PH_INSTR;
        bitcnt <= '0;
        is_rd  <= 1'b0;
      end else if (take) begin
        unique case (phase)
          PH_INSTR: begin
            ish <= ish_nx;
            if (bitcnt == '0) lsb_f <= cfg_lsb;
            if (instr_end) begin
              is_rd  <= ish_nx[INSTR_W-1];
              len    <= ish_nx[INSTR_W-2 -: LEN_W];
              addr   <= ish_nx[ADDR_W-1:0];
              nbytes <= '0;
              bitcnt <= '0;
              phase  <= PH_DATA;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          PH_DATA: begin
            dsh <= dsh_nx;
            if (byte_end) begin
              bitcnt <= '0;
              if (!is_rd) begin
                wr_en   <= 1'b1;
                wr_addr <= addr;
                wr_data <= dsh_nx;
              end
              addr   <= next_addr(addr, lsb_f);
              nbytes <= nbytes + 1'b1;
              if (last_byte) phase <= PH_DONE;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (sclk_fall && csb_low && phase == PH_DATA && is_rd)
        sdio_out <= rd_data[bit_pick(bitcnt[2:0], lsb_f)];
    end
  end

  assign sdio_oe = csb_low && (phase == PH_DATA) && is_rd;

  // R3
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && len != LEN_STREAM) |-> nbytes <= len);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> (addr == ($past(lsb_f) ? $past(addr) - 13'd1 : $past(addr) + 13'd1)));

  // R5
  out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && $past(sdio_oe) && !$past(sclk_fall)) |-> $stable(sdio_out));

  // R10
  write_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(byte_end) && !$past(is_rd));
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int          CHAN_BASE = 'h10,
  parameter int          CHAN_REGS = 8,
  parameter logic [7:0]  CHIP_ID   = 8'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              cfg_lsb
);
  localparam int NCH       = 2;
  localparam int NGLOB     = 3;
  localparam int GLOB_BASE = 'h08;
  localparam logic [NGLOB-1:0] SPARED = 3'b110;

  logic              lsb_q, srst_q;
  logic [1:0]        chan_q;
  logic [BYTE_W-1:0] glob_q [NGLOB];
  logic [BYTE_W-1:0] ch_q   [NCH][CHAN_REGS];

  logic wr_cfg, wr_chan;
  assign wr_cfg  = wr_en && wr_addr == A_CFG;
  assign wr_chan = wr_en && wr_addr == A_CHAN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q  <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= wr_cfg && (wr_data[5] || wr_data[2]);
      if (wr_cfg) lsb_q <= wr_data[6] || wr_data[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chan_q <= '0;
    else if (srst_q)  chan_q <= '0;
    else if (wr_chan) chan_q <= wr_data[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGLOB; g++) glob_q[g] <= '0;
    end else begin
      for (int g = 0; g < NGLOB; g++) begin
        if (srst_q && !SPARED[g])
          glob_q[g] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(GLOB_BASE + g))
          glob_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < CHAN_REGS; r++) ch_q[c][r] <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < CHAN_REGS; r++) begin
          if (srst_q)
            ch_q[c][r] <= '0;
          else if (wr_en && wr_addr == ADDR_W'(CHAN_BASE + r) && chan_hit(chan_q, c))
            ch_q[c][r] <= wr_data;
        end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CFG)       rd_data = cfg_view(lsb_q, srst_q);
    else if (rd_addr == A_ID)   rd_data = CHIP_ID;
    else if (rd_addr == A_CHAN) rd_data = {6'b0, chan_q};
    for (int g = 0; g < NGLOB; g++)
      if (rd_addr == ADDR_W'(GLOB_BASE + g)) rd_data = glob_q[g];
    for (int r = 0; r < CHAN_REGS; r++)
      if (rd_addr == ADDR_W'(CHAN_BASE + r))
        rd_data = (chan_q == 2'd2) ? ch_q[1][r] : ch_q[0][r];
  end

  assign cfg_lsb = lsb_q;

  // R7
  srst_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);

  // R7
  srst_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (glob_q[1] == $past(glob_q[1]) && glob_q[2] == $past(glob_q[2])
                && lsb_q == $past(lsb_q)));

  // R7
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (chan_q == 2'd0 && glob_q[0] == '0 && ch_q[0][0] == '0 && ch_q[1][0] == '0));
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         CHAN_BASE   = 'h10,
  parameter int         CHAN_REGS   = 8,
  parameter logic [7:0] CHIP_ID     = 8'h22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic csb,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe
);
  logic              sclk_rise, sclk_fall, csb_low, csb_rise, sdio_s;
  logic              cfg_lsb, wr_en;
  logic [ADDR_W-1:0] addr, wr_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_in(sdio_in),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .csb_low(csb_low),
    .csb_rise(csb_rise), .sdio_s(sdio_s)
  );

  spi_cfg_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .csb_low(csb_low), .csb_rise(csb_rise), .sdio_s(sdio_s), .cfg_lsb(cfg_lsb),
    .rd_data(rd_data), .addr(addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sdio_out(sdio_out), .sdio_oe(sdio_oe)
  );

  spi_cfg_regs #(.CHAN_BASE(CHAN_BASE), .CHAN_REGS(CHAN_REGS), .CHIP_ID(CHIP_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr), .rd_data(rd_data), .cfg_lsb(cfg_lsb)
  );

  // R5
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !sdio_oe);
endmodule

// File: tb/sim_spi_cfg_slave.sv
module sim_spi_cfg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csb = 1'b1, sdio_in = 1'b0;
  logic sdio_out, sdio_oe;

  spi_cfg_slave u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb),
                    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // bench model
  bit         m_lsb = 0;
  logic [1:0] m_chan = 0;
  logic [7:0] m_glob [3];
  logic [7:0] m_ch [2][8];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  int         oe_hits, edge_bad;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [12:0] a);
    if (a == 13'h0) return {1'b0, m_lsb, 1'b0, 2'b11, 1'b0, m_lsb, 1'b0};
    if (a == 13'h1) return 8'h22;
    if (a == 13'h5) return {6'b0, m_chan};
    if (a >= 13'h8 && a <= 13'hA) return m_glob[a - 13'h8];
    if (a >= 13'h10 && a <= 13'h17) return (m_chan == 2) ? m_ch[1][a - 13'h10] : m_ch[0][a - 13'h10];
    return 8'h00;
  endfunction

  task automatic m_wr(logic [12:0] a, logic [7:0] d);
    if (a == 13'h0) begin
      m_lsb = d[6] | d[1];
      if (d[5] | d[2]) begin
        m_chan = 0; m_glob[0] = 0;
        for (int c = 0; c < 2; c++) for (int r = 0; r < 8; r++) m_ch[c][r] = 0;
      end
    end else if (a == 13'h5) m_chan = d[1:0];
    else if (a >= 13'h8 && a <= 13'hA) m_glob[a - 13'h8] = d;
    else if (a >= 13'h10 && a <= 13'h17) begin
      if (m_chan != 2) m_ch[0][a - 13'h10] = d;
      if (m_chan != 1) m_ch[1][a - 13'h10] = d;
    end
  endtask

  function automatic logic [12:0] step(logic [12:0] a, bit lsb);
    return lsb ? a - 13'd1 : a + 13'd1;
  endfunction

  task automatic bit_io(input logic b, output logic o);
    logic o2;
    sdio_in = b;
    repeat (H) @(negedge clk);
    o = sdio_out;
    oe_hits += sdio_oe;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    o2 = sdio_out;
    if (sdio_oe && o2 !== o) edge_bad++;
    sclk = 1'b0;
  endtask

  task automatic send(input logic [15:0] v, input int n, input bit lsb, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      int idx;
      logic ob;
      idx = lsb ? i : n - 1 - i;
      bit_io(v[idx], ob);
      got[idx] = ob;
    end
  endtask

  task automatic begin_f();
    csb = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic end_f();
    repeat (H) @(negedge clk);
    csb = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic do_write(input logic [12:0] a, input logic [1:0] len, input int n);
    logic [15:0] g;
    logic [12:0] p;
    bit lsb;
    int lim;
    lsb = m_lsb; p = a; oe_hits = 0;
    lim = (len == 3) ? n : ((n < len + 1) ? n : len + 1);
    begin_f();
    send({1'b0, len, a}, 16, lsb, g);
    for (int k = 0; k < n; k++) send({8'h00, wbuf[k]}, 8, lsb, g);
    end_f();
    for (int k = 0; k < lim; k++) begin m_wr(p, wbuf[k]); p = step(p, lsb); end
  endtask

  task automatic do_read(input logic [12:0] a, input logic [1:0] len, input int n);
    logic [15:0] g;
    bit lsb;
    lsb = m_lsb; oe_hits = 0; edge_bad = 0;
    begin_f();
    send({1'b1, len, a}, 16, lsb, g);
    for (int k = 0; k < n; k++) begin send(16'h0, 8, lsb, g); rbuf[k] = g[7:0]; end
    end_f();
  endtask

  task automatic rd_chk(string req, input logic [12:0] a, input logic [1:0] len, input int n);
    logic [12:0] p;
    p = a;
    do_read(a, len, n);
    for (int k = 0; k < n; k++) begin
      check(req, rbuf[k], exp_rd(p));
      p = step(p, m_lsb);
    end
    check({req, " oe"}, oe_hits, 8 * n);
    check({req, " edge"}, edge_bad, 0);
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    wbuf[0] = d;
    do_write(a, 2'd0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] g;
    for (int i = 0; i < 3; i++) m_glob[i] = 0;
    for (int c = 0; c < 2; c++) for (int r = 0; r < 8; r++) m_ch[c][r] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 oe", sdio_oe, 0);
    rd_chk("R1 cfg", 13'h0, 2'd0, 1);
    rd_chk("R1 chan", 13'h5, 2'd0, 1);
    // R8 chip id and write ignore
    rd_chk("R8 id", 13'h1, 2'd0, 1);
    wr1(13'h1, 8'h00);
    check("R8 id after write", exp_rd(13'h1), 8'h22);
    rd_chk("R8 id kept", 13'h1, 2'd0, 1);

    // R2 R11 single byte write
    wr1(13'h8, 8'hA5);
    check("R5 oe in write", oe_hits, 0);
    rd_chk("R2 R11 glob", 13'h8, 2'd0, 1);

    // R3 extra byte ignored
    wbuf[0] = 8'h3C; wbuf[1] = 8'h77;
    do_write(13'h9, 2'd0, 2);
    rd_chk("R3 len0", 13'h9, 2'd1, 2);
    check("R3 next untouched", rbuf[1], 8'h00);

    // R3 three bytes, R4 stream read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(13'h10, 2'd2, 3);
    rd_chk("R3 R4 stream read", 13'h10, 2'd3, 4);

    // R4 stream write
    for (int k = 0; k < 5; k++) wbuf[k] = 8'h40 + 8'(k);
    do_write(13'h11, 2'd3, 5);
    rd_chk("R4 stream write", 13'h11, 2'd3, 5);
    repeat (H) @(negedge clk);
    check("R5 oe after frame", sdio_oe, 0);

    // R9 channel steering
    wr1(13'h5, 8'h01); wr1(13'h16, 8'h1A);
    wr1(13'h5, 8'h02); wr1(13'h16, 8'h2B);
    rd_chk("R9 chan B", 13'h16, 2'd0, 1);
    wr1(13'h5, 8'h01);
    rd_chk("R9 chan A", 13'h16, 2'd0, 1);
    check("R9 A copy", rbuf[0], 8'h1A);
    wr1(13'h5, 8'h03); wr1(13'h17, 8'h5E);
    rd_chk("R9 both idx3", 13'h17, 2'd0, 1);
    wr1(13'h5, 8'h02);
    rd_chk("R9 both B", 13'h17, 2'd0, 1);
    check("R9 B copy", rbuf[0], 8'h5E);
    wr1(13'h5, 8'h00);

    // R6 lsb-first
    wr1(13'h0, 8'h02);
    rd_chk("R6 cfg mirror", 13'h0, 2'd0, 1);
    check("R6 cfg value", rbuf[0], 8'h5A);
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    do_write(13'h14, 2'd2, 3);
    rd_chk("R6 descending", 13'h14, 2'd2, 3);
    check("R6 low addr", exp_rd(13'h12), 8'hC3);
    wr1(13'h0, 8'h40);
    rd_chk("R6 bit6", 13'h0, 2'd0, 1);
    wr1(13'h0, 8'h00);
    rd_chk("R6 back msb", 13'h0, 2'd0, 1);
    check("R6 msb cfg", rbuf[0], 8'h18);

    // R7 soft reset
    wr1(13'h9, 8'h99); wr1(13'hA, 8'hAA); wr1(13'h8, 8'h88); wr1(13'h5, 8'h01);
    wr1(13'h0, 8'h20);
    rd_chk("R7 cfg", 13'h0, 2'd0, 1);
    rd_chk("R7 kept 09 0A", 13'h9, 2'd1, 2);
    check("R7 keep 09", rbuf[0], 8'h99);
    rd_chk("R7 cleared 08", 13'h8, 2'd0, 1);
    check("R7 clear 08", rbuf[0], 8'h00);
    rd_chk("R7 cleared chan", 13'h5, 2'd0, 1);
    rd_chk("R7 cleared ch reg", 13'h10, 2'd0, 1);
    check("R7 ch reg", rbuf[0], 8'h00);
    wr1(13'h8, 8'h31);
    wr1(13'h0, 8'h46);
    rd_chk("R7 bit2 with lsb", 13'h0, 2'd0, 1);
    check("R7 bit2 cfg", rbuf[0], 8'h5A);
    rd_chk("R7 bit2 clears 08", 13'h8, 2'd0, 1);
    wr1(13'h0, 8'h00);

    // R10 stall at byte boundary
    begin_f();
    send({1'b0, 2'd2, 13'h8}, 16, 1'b0, g);
    send(16'h00D1, 8, 1'b0, g);
    end_f();
    begin_f();
    send(16'h00D2, 8, 1'b0, g);
    send(16'h00D3, 8, 1'b0, g);
    end_f();
    m_wr(13'h8, 8'hD1); m_wr(13'h9, 8'hD2); m_wr(13'hA, 8'hD3);
    rd_chk("R10 stall", 13'h8, 2'd2, 3);
    check("R10 third", rbuf[2], 8'hD3);
    // R10 mid-byte abort
    begin_f();
    send({1'b0, 2'd0, 13'h9}, 16, 1'b0, g);
    send(16'h000F, 4, 1'b0, g);
    end_f();
    rd_chk("R10 abort", 13'h9, 2'd0, 1);
    check("R10 partial dropped", rbuf[0], 8'hD2);

    // R11 unmapped
    wr1(13'h100, 8'h55);
    rd_chk("R11 unmapped", 13'h100, 2'd0, 1);
    check("R11 unmapped zero", rbuf[0], 8'h00);

    // random mix
    begin
      int seed_dummy;
      seed_dummy = $urandom(1234);
      for (int it = 0; it < 40; it++) begin
        logic [12:0] a;
        logic [1:0]  ln;
        int sel;
        sel = $urandom_range(0, 11);
        a = (sel == 0) ? 13'h5 : (sel < 4) ? 13'(7 + sel) : 13'(16 + sel - 4);
        ln = 2'($urandom_range(0, 2));
        if ($urandom_range(0, 7) == 0) wr1(13'h0, $urandom_range(0, 1) ? 8'h02 : 8'h00);
        for (int k = 0; k < 3; k++) wbuf[k] = 8'($urandom);
        do_write(a, ln, int'(ln) + 1);
        rd_chk("R2 R3 R9 R11 random", a, ln, int'(ln) + 1);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule